// File: doc/BRIEF.md
# Go-Back-N Link Retry Controller

This block pairs a transmit engine and a receive engine for a point-to-point message link. Messages enter from the upper layer through a valid/ready handshake. The transmit engine prefixes each message with a sequence number and appends a CRC check value. It sends the frame toward the physical channel and keeps the payload in a retry window of `N` slots.

The receive engine checks each frame that comes back from the channel. A frame must carry a correct CRC and the sequence number it expects next. It delivers good payloads in order, and it acknowledges the transmit engine after every `N` good frames, which frees the whole window. When a frame fails, the receive engine asks for a retry that names the sequence number it wants next. It then discards all arriving frames until the transmit engine grants the retry. The transmit engine rewinds to that sequence number and resends from its window, in order, before it accepts any new message.

The acknowledge, retry-request and retry-grant signals run between the two engines inside the block. The channel between `phy_tx_*` and `phy_rx_*` is external. It may have latency, but it must keep frames in order. `N` must be a power of two no smaller than 2, and the sequence width must cover at least `2N` values.

Top module: `gbn_link`

## Requirements
- R1: Every transmitted frame holds the sequence number in its top `SW` bits, then `DW` data bits, then the `CW`-bit CRC in the lowest bits. The CRC covers the sequence and data bits, most significant bit first. The CRC register starts at zero and shifts left on each bit. It is XORed with `POLY` whenever the message bit XOR the register's top bit is 1.
- R2: A message is taken only in a cycle where its frame is also transferred on the transmit channel. New messages carry consecutive sequence numbers, modulo 2^SW, starting at 0 after reset.
- R3: The sender never holds more than `N` unacknowledged messages, and `src_ready` stays low while `N` are held. On a channel that is always ready with a two-cycle delay and a continuous source, `src_ready` is low in cycles 4, 5 and 6 after reset.
- R4: The receiver raises `dst_valid` for exactly one cycle, in the cycle after a good frame arrives, with that frame's data. Deliveries follow the order in which messages were taken, with no gap and no duplicate. `dst_valid` is low otherwise.
- R5: An acknowledgement is issued after every `N` good frames. The good-frame counter restarts at zero on each acknowledgement and on each retry request. The acknowledgement frees the whole window, so the source is accepted again from the second cycle after the `N`th good arrival (cycle 7 in the R3 scenario).
- R6: A frame with a bad CRC or an unexpected sequence number, arriving while the receiver is in its running state, raises a retry request in the next cycle. The request names the sequence number the receiver expects.
- R7: From a retry request until the retry grant, the receiver discards every arriving frame. This covers the two cycles after the failing arrival. Frames are checked again from the third cycle.
- R8: The sender grants a retry in the cycle after the request and sends nothing during the request and grant cycles. It then resends the stored messages from the named sequence number in order, before any new message.
- R9: A retry grant never occurs without a retry request in the previous cycle. The window base moves only in the cycle after an acknowledgement or a retry request.
- R10: During reset, `dst_valid` is low, `phy_tx_valid` is low while `src_valid` is low, and `src_ready` follows `phy_tx_ready`.

Transmit states: `SND_FRESH` sends new messages. It goes to `SND_GRANT` on a retry request. `SND_GRANT` drives the retry grant for one cycle. It then goes to `SND_RESEND` if stored messages remain to be sent, or to `SND_FRESH` if none remain. `SND_RESEND` replays the window. It returns to `SND_FRESH` after its last stored frame, or goes back to `SND_GRANT` on a new request.

Receive states: `RCV_RUN` checks and delivers frames. It goes to `RCV_DROP` on a failing frame. `RCV_DROP` discards frames and returns to `RCV_RUN` on the retry grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Upper layer offers a message |
| src_data | input | DW | Message payload |
| src_ready | output | 1 | Message taken this cycle when high with src_valid |
| phy_tx_valid | output | 1 | Frame offered to the channel |
| phy_tx_ready | input | 1 | Channel accepts the frame this cycle |
| phy_tx_frame | output | SW+DW+CW | Outgoing frame {seq, data, crc} |
| phy_rx_valid | input | 1 | Frame arriving from the channel |
| phy_rx_frame | input | SW+DW+CW | Arriving frame |
| dst_valid | output | 1 | Delivered payload valid (one cycle) |
| dst_data | output | DW | Delivered payload |

## Verification
The properties assume that arriving frames come from this block's own transmit side, in order, through a lossless channel. Under that assumption, a retry request can only arise while the receiver is running, and a replayed sequence number always lies inside the window. The bench keeps within this with a two-stage in-order pipeline as the channel, and it never drops or reorders frames. Its only fault is a single flipped bit in a randomly chosen frame, which any CRC with more than one polynomial term detects. Every injected fault therefore leads to a detected failure and a replay.

// File: rtl/gbn_pkg.sv
`timescale 1ns/1ps
package gbn_pkg;

    typedef enum logic [1:0] {
        SND_FRESH  = 2'd0,
        SND_RESEND = 2'd1,
        SND_GRANT  = 2'd2
    } snd_state_e;

    typedef enum logic {
        RCV_RUN  = 1'b0,
        RCV_DROP = 1'b1
    } rcv_state_e;

endpackage

// File: rtl/gbn_crc.sv
`timescale 1ns/1ps
module gbn_crc #(
    parameter int            IW   = 20,
    parameter int            CW   = 8,
    parameter logic [CW-1:0] POLY = CW'(7)
) (
    input  logic [IW-1:0] msg,
    output logic [CW-1:0] crc
);

    always_comb begin
        logic [CW-1:0] r;
        logic          fb;
        r = '0;
        for (int i = IW - 1; i >= 0; i--) begin
            fb = msg[i] ^ r[CW-1];
            r  = {r[CW-2:0], 1'b0};
            if (fb) begin
                r = r ^ POLY;
            end
        end
        crc = r;
    end

endmodule

// File: rtl/gbn_sender.sv
`timescale 1ns/1ps
module gbn_sender
    import gbn_pkg::*;
#(
    parameter int            DW   = 16,
    parameter int            SW   = 4,
    parameter int            N    = 4,
    parameter int            CW   = 8,
    parameter logic [CW-1:0] POLY = CW'(7)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  src_valid,
    input  logic [DW-1:0]         src_data,
    output logic                  src_ready,
    output logic                  tx_valid,
    input  logic                  tx_ready,
    output logic [SW+DW+CW-1:0]   tx_frame,
    input  logic                  ack_i,
    input  logic                  retry_req_i,
    input  logic [SW-1:0]         retry_seq_i,
    output logic                  retry_ack_o,
    output logic [SW-1:0]         base_o,
    output logic [SW-1:0]         next_o
);

    localparam int            PW  = SW + DW;
    localparam int            AW  = (N > 1) ? $clog2(N) : 1;
    localparam logic [SW:0]   WIN = (SW+1)'(N);

    snd_state_e       st_q, st_d;
    logic [SW-1:0]    base_q, next_q, rd_q, rd_inc, held;
    logic [DW-1:0]    slot_q [N];
    logic [PW-1:0]    payload;
    logic [CW-1:0]    crc;
    logic             full, fire;

    assign held   = next_q - base_q;
    assign full   = ({1'b0, held} == WIN);
    assign rd_inc = rd_q + 1'b1;
    assign fire   = tx_valid && tx_ready;

    // outputs per state
    always_comb begin
        src_ready   = 1'b0;
        tx_valid    = 1'b0;
        retry_ack_o = 1'b0;
        payload     = {next_q, src_data};
        unique case (st_q)
            SND_FRESH: begin
                tx_valid  = src_valid && !full && !retry_req_i;
                src_ready = tx_ready && !full && !retry_req_i;
            end
            SND_RESEND: begin
                tx_valid = !retry_req_i;
                payload  = {rd_q, slot_q[rd_q[AW-1:0]]};
            end
            SND_GRANT: begin
                retry_ack_o = 1'b1;
            end
            default: begin
                tx_valid = 1'b0;
            end
        endcase
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SND_FRESH: begin
                if (retry_req_i) st_d = SND_GRANT;
            end
            SND_RESEND: begin
                if (retry_req_i)                   st_d = SND_GRANT;
                else if (fire && rd_inc == next_q) st_d = SND_FRESH;
            end
            SND_GRANT: begin
                st_d = (rd_q == next_q) ? SND_FRESH : SND_RESEND;
            end
            default: st_d = SND_FRESH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SND_FRESH;
        else        st_q <= st_d;
    end

    // window pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            next_q <= '0;
            rd_q   <= '0;
        end else if (st_q != SND_GRANT && retry_req_i) begin
            base_q <= retry_seq_i;
            rd_q   <= retry_seq_i;
        end else begin
            if (ack_i) base_q <= next_q;
            if (fire) begin
                rd_q <= rd_inc;
                if (st_q == SND_FRESH) next_q <= next_q + 1'b1;
            end
        end
    end

    // retry window storage
    always_ff @(posedge clk) begin
        if (fire && st_q == SND_FRESH) begin
            slot_q[next_q[AW-1:0]] <= src_data;
        end
    end

    gbn_crc #(.IW(PW), .CW(CW), .POLY(POLY)) crc_i (
        .msg (payload),
        .crc (crc)
    );

    assign tx_frame = {payload, crc};
    assign base_o   = base_q;
    assign next_o   = next_q;

endmodule

// File: rtl/gbn_receiver.sv
`timescale 1ns/1ps
module gbn_receiver
    import gbn_pkg::*;
#(
    parameter int            DW   = 16,
    parameter int            SW   = 4,
    parameter int            N    = 4,
    parameter int            CW   = 8,
    parameter logic [CW-1:0] POLY = CW'(7)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [SW+DW+CW-1:0]   rx_frame,
    output logic                  dst_valid,
    output logic [DW-1:0]         dst_data,
    output logic                  ack_o,
    output logic                  retry_req_o,
    output logic [SW-1:0]         retry_seq_o,
    input  logic                  retry_ack_i,
    output logic                  drop_o
);

    localparam int             FW   = SW + DW + CW;
    localparam int             CNW  = $clog2(N + 1);
    localparam logic [CNW-1:0] LAST = CNW'(N - 1);

    rcv_state_e      st_q, st_d;
    logic [SW-1:0]   exp_q;
    logic [CNW-1:0]  good_q;
    logic [CW-1:0]   calc;
    logic [SW-1:0]   rx_seq;
    logic [DW-1:0]   rx_data;
    logic            pass, take, reject;
    logic            dvalid_q, ack_q, req_q;
    logic [DW-1:0]   ddata_q;
    logic [SW-1:0]   rseq_q;

    assign rx_seq  = rx_frame[FW-1 -: SW];
    assign rx_data = rx_frame[CW +: DW];
    assign pass    = (calc == rx_frame[CW-1:0]) && (rx_seq == exp_q);

    gbn_crc #(.IW(SW + DW), .CW(CW), .POLY(POLY)) chk_crc_i (
        .msg (rx_frame[FW-1:CW]),
        .crc (calc)
    );

    // outputs per state
    always_comb begin
        take   = 1'b0;
        reject = 1'b0;
        drop_o = 1'b0;
        unique case (st_q)
            RCV_RUN: begin
                take   = rx_valid && pass;
                reject = rx_valid && !pass;
            end
            RCV_DROP: begin
                drop_o = 1'b1;
            end
            default: drop_o = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RCV_RUN:  if (reject)      st_d = RCV_DROP;
            RCV_DROP: if (retry_ack_i) st_d = RCV_RUN;
            default:  st_d = RCV_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RCV_RUN;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q    <= '0;
            good_q   <= '0;
            dvalid_q <= 1'b0;
            ddata_q  <= '0;
            ack_q    <= 1'b0;
            req_q    <= 1'b0;
            rseq_q   <= '0;
        end else begin
            dvalid_q <= take;
            ack_q    <= take && (good_q == LAST);
            req_q    <= reject;
            if (take) begin
                ddata_q <= rx_data;
                exp_q   <= exp_q + 1'b1;
                good_q  <= (good_q == LAST) ? '0 : good_q + 1'b1;
            end else if (reject) begin
                good_q <= '0;
                rseq_q <= exp_q;
            end
        end
    end

    assign dst_valid   = dvalid_q;
    assign dst_data    = ddata_q;
    assign ack_o       = ack_q;
    assign retry_req_o = req_q;
    assign retry_seq_o = rseq_q;

endmodule

// File: rtl/gbn_link.sv
`timescale 1ns/1ps
module gbn_link #(
    parameter int            DW   = 16,
    parameter int            SW   = 4,
    parameter int            N    = 4,
    parameter int            CW   = 8,
    parameter logic [CW-1:0] POLY = CW'(7)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  src_valid,
    input  logic [DW-1:0]         src_data,
    output logic                  src_ready,
    output logic                  phy_tx_valid,
    input  logic                  phy_tx_ready,
    output logic [SW+DW+CW-1:0]   phy_tx_frame,
    input  logic                  phy_rx_valid,
    input  logic [SW+DW+CW-1:0]   phy_rx_frame,
    output logic                  dst_valid,
    output logic [DW-1:0]         dst_data
);

    logic          lk_ack;
    logic          lk_retry_req;
    logic [SW-1:0] lk_retry_seq;
    logic          lk_retry_ack;
    logic [SW-1:0] mon_base;
    logic [SW-1:0] mon_next;
    logic          mon_drop;

    gbn_sender #(.DW(DW), .SW(SW), .N(N), .CW(CW), .POLY(POLY)) snd_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_valid   (src_valid),
        .src_data    (src_data),
        .src_ready   (src_ready),
        .tx_valid    (phy_tx_valid),
        .tx_ready    (phy_tx_ready),
        .tx_frame    (phy_tx_frame),
        .ack_i       (lk_ack),
        .retry_req_i (lk_retry_req),
        .retry_seq_i (lk_retry_seq),
        .retry_ack_o (lk_retry_ack),
        .base_o      (mon_base),
        .next_o      (mon_next)
    );

    gbn_receiver #(.DW(DW), .SW(SW), .N(N), .CW(CW), .POLY(POLY)) rcv_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (phy_rx_valid),
        .rx_frame    (phy_rx_frame),
        .dst_valid   (dst_valid),
        .dst_data    (dst_data),
        .ack_o       (lk_ack),
        .retry_req_o (lk_retry_req),
        .retry_seq_o (lk_retry_seq),
        .retry_ack_i (lk_retry_ack),
        .drop_o      (mon_drop)
    );

endmodule

// File: rtl/gbn_link_chk.sv
`timescale 1ns/1ps
module gbn_link_chk #(
    parameter int SW = 4,
    parameter int N  = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic          retry_req,
    input logic          retry_ack,
    input logic [SW-1:0] base_seq,
    input logic [SW-1:0] next_seq,
    input logic          rcv_drop,
    input logic          rx_valid,
    input logic          dst_valid,
    input logic          src_ready
);

    localparam logic [SW:0] WIN = (SW+1)'(N);

    logic [SW-1:0] held;
    assign held = next_seq - base_seq;

    // R3: window occupancy bounded by N
    a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, held} <= WIN));

    // R3: full window blocks the source
    a_r3_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, held} == WIN) |-> !src_ready);

    // R7: frames seen while discarding are never delivered
    a_r7_drop_no_delivery: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_drop && rx_valid) |=> !dst_valid);

    // R9: grant only follows a request
    a_r9_grant_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        retry_ack |-> $past(retry_req));

    // R8: grant comes in the cycle after the request
    a_r8_req_then_grant: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |=> retry_ack);

    // R9: window base moves only after ack or retry request
    a_r9_base_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (base_seq != $past(base_seq)) |-> ($past(ack) || $past(retry_req)));

    // R5: ack, request and grant are mutually exclusive
    a_r5_ctrl_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack, retry_req, retry_ack}));

endmodule

bind gbn_link gbn_link_chk #(.SW(SW), .N(N)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (lk_ack),
    .retry_req (lk_retry_req),
    .retry_ack (lk_retry_ack),
    .base_seq  (mon_base),
    .next_seq  (mon_next),
    .rcv_drop  (mon_drop),
    .rx_valid  (phy_rx_valid),
    .dst_valid (dst_valid),
    .src_ready (src_ready)
);

// File: tb/gbn_link_tb_top.sv
`timescale 1ns/1ps
module gbn_link_tb_top;

    localparam int            DW     = 16;
    localparam int            SW     = 4;
    localparam int            N      = 4;
    localparam int            CW     = 8;
    localparam logic [CW-1:0] POLY   = 8'h07;
    localparam int            FW     = SW + DW + CW;
    localparam int            TARGET = 500;
    localparam int            LIMIT  = 60000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          src_valid, src_ready;
    logic [DW-1:0] src_data;
    logic          tx_valid, tx_ready;
    logic [FW-1:0] tx_frame;
    logic          rx_valid;
    logic [FW-1:0] rx_frame;
    logic          dst_valid;
    logic [DW-1:0] dst_data;

    always #2.5 clk = ~clk;

    gbn_link #(.DW(DW), .SW(SW), .N(N), .CW(CW), .POLY(POLY)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_valid    (src_valid),
        .src_data     (src_data),
        .src_ready    (src_ready),
        .phy_tx_valid (tx_valid),
        .phy_tx_ready (tx_ready),
        .phy_tx_frame (tx_frame),
        .phy_rx_valid (rx_valid),
        .phy_rx_frame (rx_frame),
        .dst_valid    (dst_valid),
        .dst_data     (dst_data)
    );

    // two-stage in-order channel with optional single-bit corruption
    logic          flip_now;
    logic [FW-1:0] flip_mask;
    logic          p0_v, p1_v, p0_c, p1_c;
    logic [FW-1:0] p0_f, p1_f;

    always @(posedge clk) begin
        if (!rst_n) begin
            p0_v <= 1'b0; p1_v <= 1'b0; p0_c <= 1'b0; p1_c <= 1'b0;
            p0_f <= '0;   p1_f <= '0;
        end else begin
            p0_v <= tx_valid && tx_ready;
            p0_f <= tx_frame ^ (flip_now ? flip_mask : '0);
            p0_c <= flip_now;
            p1_v <= p0_v;
            p1_f <= p0_f;
            p1_c <= p0_c;
        end
    end
    assign rx_valid = p1_v;
    assign rx_frame = p1_f;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] ref_crc(input logic [FW-CW-1:0] m);
        logic [CW-1:0] r;
        logic          fb;
        r = '0;
        for (int i = FW - CW - 1; i >= 0; i--) begin
            fb = m[i] ^ r[CW-1];
            r  = {r[CW-2:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    // reference model state
    logic [DW-1:0] sent_q[$];
    int  acc = 0;      // messages taken
    int  rp = 0;       // index of next frame expected on the transmit side
    int  mdel = 0;     // messages delivered
    int  base_m = 0;   // first unacknowledged index
    int  good_m = 0;
    int  drop_cnt = 0;
    int  n_err = 0;
    int  n_drop = 0;
    int  win = 0;
    bit  exp_v, was_drop, hold;
    logic [DW-1:0] exp_d;

    initial begin
        rst_n = 1'b0; src_valid = 1'b0; src_data = '0;
        tx_ready = 1'b1; flip_now = 1'b0; flip_mask = '0;
        hold = 1'b0; exp_v = 1'b0; was_drop = 1'b0; exp_d = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(dst_valid == 1'b0, "R10", "dst_valid in reset", dst_valid, 0);
        chk(tx_valid == 1'b0, "R10", "tx_valid in reset", tx_valid, 0);
        chk(src_ready == 1'b1, "R10", "src_ready in reset", src_ready, 1);
        rst_n = 1'b1;

        while (mdel < TARGET && win < LIMIT) begin
            // drive this cycle
            src_valid = (win < 40) ? 1'b1 : ($urandom_range(0, 9) < 8);
            if (!hold) begin
                src_data = DW'($urandom);
                hold = 1'b1;
            end
            tx_ready  = (win < 40) ? 1'b1 : ($urandom_range(0, 7) != 0);
            flip_now  = (win >= 40) && (mdel < TARGET - 20) && ($urandom_range(0, 11) == 0);
            flip_mask = FW'(1) << $urandom_range(0, FW - 1);
            #1;

            // directed window fill and release after reset
            if (win >= 4 && win <= 6)
                chk(src_ready == 1'b0, "R3", "stall with full window", src_ready, 0);
            if (win == 7)
                chk(src_ready == 1'b1, "R5", "release after ack", src_ready, 1);

            // R3: never more than N outstanding while accepting
            if (src_ready)
                chk(acc - base_m < N, "R3", "outstanding while ready", acc - base_m, N - 1);

            if (src_valid && src_ready && !(tx_valid && tx_ready))
                chk(1'b0, "R2", "taken without transfer", 1, 0);

            // transmit side
            if (tx_valid && tx_ready) begin
                chk(tx_frame[CW-1:0] == ref_crc(tx_frame[FW-1:CW]), "R1", "crc",
                    tx_frame[CW-1:0], ref_crc(tx_frame[FW-1:CW]));
                chk(tx_frame[FW-1 -: SW] == SW'(rp), "R8", "frame seq",
                    tx_frame[FW-1 -: SW], SW'(rp));
                if (rp == acc) begin
                    chk(src_valid && src_ready, "R2", "new frame handshake", src_ready, 1);
                    chk(tx_frame[CW +: DW] == src_data, "R2", "new data",
                        tx_frame[CW +: DW], src_data);
                    sent_q.push_back(src_data);
                    acc++;
                    hold = 1'b0;
                end else begin
                    chk(!(src_valid && src_ready), "R8", "new taken during replay", src_ready, 0);
                    chk(tx_frame[CW +: DW] == sent_q[rp], "R8", "replay data",
                        tx_frame[CW +: DW], sent_q[rp]);
                end
                rp++;
            end

            // receive side
            exp_v    = 1'b0;
            was_drop = (drop_cnt > 0);
            if (drop_cnt > 0) drop_cnt--;
            if (rx_valid && was_drop) begin
                n_drop++;
            end else if (rx_valid) begin
                if (!p1_c && rx_frame[FW-1 -: SW] == SW'(mdel)) begin
                    exp_v = 1'b1;
                    exp_d = sent_q[mdel];
                    mdel++;
                    good_m++;
                    if (good_m == N) begin
                        good_m = 0;
                        base_m = mdel;
                    end
                end else begin
                    // R6: retry names the next expected index; replay restarts there
                    n_err++;
                    drop_cnt = 2;
                    rp = mdel;
                    base_m = mdel;
                    good_m = 0;
                    was_drop = 1'b1;
                end
            end

            @(negedge clk);
            win++;
            if (exp_v) begin
                chk(dst_valid == 1'b1, "R4", "delivery valid", dst_valid, 1);
                chk(dst_data == exp_d, "R4", "delivery data", dst_data, exp_d);
            end else begin
                chk(dst_valid == 1'b0, was_drop ? "R7" : "R4", "no delivery", dst_valid, 0);
            end
        end

        if (win >= LIMIT)
            chk(1'b0, "R5", "watchdog expired", mdel, TARGET);
        chk(mdel >= TARGET, "R4", "delivered count", mdel, TARGET);
        chk(n_err > 0, "R6", "failures exercised", n_err, 1);
        chk(n_drop > 0, "R7", "discards exercised", n_drop, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule